// File: doc/BRIEF.md
# Fractional PLL Retuning Word Updater

This block keeps an external clock synthesizer tracking a moving carrier phase. On every update strobe (nominally one every 125 us, an 8 kHz rate) it takes a target VCO frequency in hertz. It expresses that frequency as a feedback ratio `a + b/c` against a 27 MHz reference, where `c` is the fixed denominator 0xFFFFF. The ratio is then written to the synthesizer as one I2C write burst.

A single restoring long-division sequencer is used twice per update. The first pass divides the frequency by the reference to get the integer part `a` and a remainder. The second pass divides `remainder * 0xFFFFF + carried residue` by the reference to get the numerator `b`. The remainder of the second pass becomes the residue for the next update. The truncation error therefore never builds up into a steady phase drift.

The top controller has four states:

- `S_IDLE`: waiting for a strobe. An accepted strobe moves to `S_DIV_INT`.
- `S_DIV_INT`: the integer pass. Divider done moves to `S_DIV_FRAC`.
- `S_DIV_FRAC`: the numerator pass. Divider done moves to `S_SEND` and starts the burst.
- `S_SEND`: the burst is on the bus. Burst done returns to `S_IDLE`.

The I2C engine has five states:

- `I_IDLE`: bus released.
- `I_START`: start condition. Moves to `I_DATA`.
- `I_DATA`: eight bits, MSB first. Moves to `I_ACK`.
- `I_ACK`: acknowledge slot. Moves back to `I_DATA` for the next byte, or to `I_STOP`.
- `I_STOP`: stop condition. Moves back to `I_IDLE`.

Each SCL period is four quarter phases of `QTR` clock cycles.

Top module: `pll_ratio_streamer`

## Requirements
- R1: `ratio_int` equals floor(f / 27e6) for the accepted target f. This includes f below the reference, where it is 0.
- R2: `ratio_num` equals floor((r0 * 0xFFFFF + res) / 27e6), where r0 = f mod 27e6. Here `res` is the remainder left by the previous update's numerator division (0 after reset), and the new remainder replaces it. Example: f = 880200000 right after reset gives int 32 and num 0x99999.
- R3: When that numerator quotient reaches 0xFFFFF, the result becomes int + 1 with num 0. `ratio_num` therefore never exceeds 0xFFFFE.
- R4: Each accepted update produces one I2C frame: a START, then 7 bytes MSB first, then a STOP. The bytes are, in order:
  - {DEV_ADDR, 0}
  - START_REG
  - the integer byte
  - 0x00
  - {4'h0, num[19:16]}
  - num[15:8]
  - num[7:0]
- R5: With `ack_ignore` = 0, a NACK (SDA high while SCL is high in the ninth bit slot) ends the frame with a STOP right after that byte.
- R6: With `ack_ignore` = 1, all 7 bytes are sent regardless of the acknowledge bits.
- R7: After reset, `busy` is 0, `overrun` is 0, and SCL and SDA are 1. `busy` rises in the cycle after an accepted strobe and stays high until the STOP has completed.
- R8: A strobe that arrives while `busy` is high is dropped. `overrun` is high for exactly the following cycle, and the results and frame of the running update are unchanged.
- R9: SCL is high for 2*QTR cycles per bit. SDA changes only while SCL is low, except for the START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | Update strobe, one cycle |
| target_hz | input | FREQ_W | Target VCO frequency in Hz |
| ack_ignore | input | 1 | 1: do not stop on NACK |
| sda_in | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level driven (1 = released) |
| busy | output | 1 | Update in progress |
| overrun | output | 1 | One-cycle pulse for a dropped strobe |
| ratio_int | output | INT_W | Last integer multiplier |
| ratio_num | output | NUM_W | Last fractional numerator |

## Verification
The collision that matters is a fresh strobe landing while an earlier update is still dividing or on the bus. Admission of a new update and rejection-with-flag then compete in the same cycle. The bench fires a second strobe with a different frequency a few cycles after the first. It expects `overrun` in exactly the next cycle and gone one cycle later. It then expects a single START/STOP pair whose bytes and ratio outputs match the first frequency alone, with the residue chain advanced only once.

// File: rtl/pll_upd_pkg.sv
package pll_upd_pkg;
    typedef enum logic [1:0] {S_IDLE, S_DIV_INT, S_DIV_FRAC, S_SEND} upd_state_t;
    typedef enum logic [2:0] {I_IDLE, I_START, I_DATA, I_ACK, I_STOP} i2c_state_t;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/restoring_div.sv
module restoring_div #(
    parameter int DW      = 46,
    parameter int DIVISOR = 27_000_000,
    parameter int QOUT_W  = 21,
    localparam int RW     = $clog2(DIVISOR) + 1,
    localparam int CW     = $clog2(DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     dividend,
    output logic              done,
    output logic [QOUT_W-1:0] quot,
    output logic [RW-1:0]     rem
);
    localparam logic [RW-1:0] DIV_V = RW'(DIVISOR);

    logic [DW-1:0] work;
    logic [RW-1:0] trial;
    logic [CW-1:0] cnt;
    logic          running;

    always_comb trial = {rem[RW-2:0], work[DW-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work    <= '0;
            rem     <= '0;
            cnt     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                work    <= dividend;
                rem     <= '0;
                cnt     <= CW'(DW);
                running <= 1'b1;
            end else if (running) begin
                if (trial >= DIV_V) begin
                    rem  <= trial - DIV_V;
                    work <= {work[DW-2:0], 1'b1};
                end else begin
                    rem  <= trial;
                    work <= {work[DW-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    assign quot = work[QOUT_W-1:0];

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        rem < DIV_V); // R2
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(running) && !running)); // R2
endmodule

// File: rtl/i2c_burst_tx.sv
module i2c_burst_tx
    import pll_upd_pkg::*;
#(
    parameter int          QTR       = 50,
    parameter logic [6:0]  DEV_ADDR  = 7'h60,
    parameter logic [7:0]  START_REG = 8'd26,
    parameter int          PAY_BYTES = 5,
    localparam int NBYTES = PAY_BYTES + 2,
    localparam int SW     = BYTE_W * NBYTES,
    localparam int QW     = $clog2(QTR),
    localparam int BNW    = $clog2(NBYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [BYTE_W*PAY_BYTES-1:0]  payload,
    input  logic                         ack_ignore,
    input  logic                         sda_in,
    output logic                         scl_o,
    output logic                         sda_o,
    output logic                         done
);
    i2c_state_t      state;
    logic [QW-1:0]   qcnt;
    logic [1:0]      ph;
    logic [2:0]      bitn;
    logic [BNW-1:0]  byten;
    logic [SW-1:0]   shreg;
    logic            nack;
    logic            tick;

    assign tick = (qcnt == QW'(QTR - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= I_IDLE;
            qcnt  <= '0;
            ph    <= '0;
            bitn  <= '0;
            byten <= '0;
            shreg <= '0;
            nack  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == I_IDLE) begin
                if (start) begin
                    state <= I_START;
                    qcnt  <= '0;
                    ph    <= '0;
                    bitn  <= '0;
                    byten <= '0;
                    shreg <= {DEV_ADDR, 1'b0, START_REG, payload};
                end
            end else if (tick) begin
                qcnt <= '0;
                ph   <= ph + 1'b1;
                if (state == I_ACK && ph == 2'd2) nack <= sda_in;
                if (ph == 2'd3) begin
                    unique case (state)
                        I_START: state <= I_DATA;
                        I_DATA: begin
                            shreg <= shreg << 1;
                            if (bitn == 3'd7) begin
                                bitn  <= '0;
                                state <= I_ACK;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end
                        I_ACK: begin
                            if ((nack && !ack_ignore) || byten == BNW'(NBYTES - 1)) begin
                                state <= I_STOP;
                            end else begin
                                byten <= byten + 1'b1;
                                state <= I_DATA;
                            end
                        end
                        I_STOP: begin
                            state <= I_IDLE;
                            done  <= 1'b1;
                        end
                        default: state <= I_IDLE;
                    endcase
                end
            end else begin
                qcnt <= qcnt + 1'b1;
            end
        end
    end

    always_comb begin
        scl_o = 1'b1;
        sda_o = 1'b1;
        unique case (state)
            I_IDLE:  begin scl_o = 1'b1;                  sda_o = 1'b1;          end
            I_START: begin scl_o = (ph < 2'd2);           sda_o = (ph == 2'd0);  end
            I_DATA:  begin scl_o = (ph == 2'd1 || ph == 2'd2); sda_o = shreg[SW-1]; end
            I_ACK:   begin scl_o = (ph == 2'd1 || ph == 2'd2); sda_o = 1'b1;    end
            I_STOP:  begin scl_o = (ph != 2'd0);          sda_o = (ph >= 2'd2);  end
            default: begin scl_o = 1'b1;                  sda_o = 1'b1;          end
        endcase
    end

    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == I_DATA && ph == 2'd2) |-> $stable(sda_o)); // R9
    AST_DONE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (scl_o && sda_o && $past(scl_o))); // R4
endmodule

// File: rtl/pll_ratio_streamer.sv
module pll_ratio_streamer
    import pll_upd_pkg::*;
#(
    parameter int         REF_HZ    = 27_000_000,
    parameter int         FREQ_W    = 32,
    parameter int         INT_W     = 8,
    parameter int         NUM_W     = 20,
    parameter int         FRAC_DEN  = 20'hFFFFF,
    parameter logic [6:0] DEV_ADDR  = 7'h60,
    parameter logic [7:0] START_REG = 8'd26,
    parameter int         QTR       = 50,
    localparam int RW  = $clog2(REF_HZ) + 1,
    localparam int DW  = (FREQ_W > RW + NUM_W) ? FREQ_W : RW + NUM_W,
    localparam int QOW = (INT_W > NUM_W + 1) ? INT_W : NUM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_stb,
    input  logic [FREQ_W-1:0] target_hz,
    input  logic              ack_ignore,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              busy,
    output logic              overrun,
    output logic [INT_W-1:0]  ratio_int,
    output logic [NUM_W-1:0]  ratio_num
);
    upd_state_t state, state_nx;

    logic             div_start, div_done, tx_start, tx_done, wrap;
    logic [DW-1:0]    div_in;
    logic [QOW-1:0]   div_quot;
    logic [RW-1:0]    div_rem;
    logic [RW-1:0]    residue;
    logic [INT_W-1:0] int_hold, new_int;
    logic [NUM_W-1:0] new_num;
    logic [NUM_W:0]   frac_q;
    logic [39:0]      payload;

    restoring_div #(.DW(DW), .DIVISOR(REF_HZ), .QOUT_W(QOW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_in),
        .done(div_done), .quot(div_quot), .rem(div_rem)
    );

    i2c_burst_tx #(.QTR(QTR), .DEV_ADDR(DEV_ADDR), .START_REG(START_REG), .PAY_BYTES(5)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .payload(payload),
        .ack_ignore(ack_ignore), .sda_in(sda_in), .scl_o(scl_o), .sda_o(sda_o), .done(tx_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (upd_stb)  state_nx = S_DIV_INT;
            S_DIV_INT:  if (div_done) state_nx = S_DIV_FRAC;
            S_DIV_FRAC: if (div_done) state_nx = S_SEND;
            S_SEND:     if (tx_done)  state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        div_start = (state == S_IDLE && upd_stb) || (state == S_DIV_INT && div_done);
        div_in    = (state == S_IDLE) ? DW'(target_hz)
                                      : DW'(div_rem) * DW'(FRAC_DEN) + DW'(residue);
        frac_q    = div_quot[NUM_W:0];
        wrap      = (frac_q == (NUM_W + 1)'(FRAC_DEN));
        new_int   = int_hold + INT_W'(wrap);
        new_num   = wrap ? '0 : frac_q[NUM_W-1:0];
        tx_start  = (state == S_DIV_FRAC && div_done);
        payload   = {8'(new_int), 8'h00, 24'(new_num)};
        busy      = (state != S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_hold  <= '0;
            ratio_int <= '0;
            ratio_num <= '0;
            residue   <= '0;
            overrun   <= 1'b0;
        end else begin
            overrun <= upd_stb && (state != S_IDLE);
            if (state == S_DIV_INT && div_done) int_hold <= div_quot[INT_W-1:0];
            if (tx_start) begin
                ratio_int <= new_int;
                ratio_num <= new_num;
                residue   <= div_rem;
            end
        end
    end

    AST_DROP_FLAGS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && busy) |=> overrun); // R8
    AST_IDLE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy)) |-> !overrun); // R8
    AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !busy) |=> busy); // R7
    AST_NUM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_num < NUM_W'(FRAC_DEN)); // R3
endmodule

// File: tb/pll_ratio_streamer_tb.sv
`timescale 1ns/100ps
module pll_ratio_streamer_tb;
    localparam int QTR_TB = 4;
    localparam longint unsigned REF = 27_000_000;
    localparam longint unsigned DEN = 1048575;

    logic clk = 1'b0, rst_n = 1'b0, upd_stb = 1'b0, ack_ignore = 1'b0;
    logic [31:0] target_hz = '0;
    logic scl_o, sda_o, busy, overrun, sda_line;
    logic [7:0]  ratio_int;
    logic [19:0] ratio_num;
    logic slave_pull = 1'b0, slave_ack = 1'b1;

    always #2.5 clk = ~clk;
    assign sda_line = sda_o & ~slave_pull;

    pll_ratio_streamer #(.QTR(QTR_TB)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .target_hz(target_hz),
        .ack_ignore(ack_ignore), .sda_in(sda_line), .scl_o(scl_o), .sda_o(sda_o),
        .busy(busy), .overrun(overrun), .ratio_int(ratio_int), .ratio_num(ratio_num)
    );

    int checks = 0, fails = 0, starts = 0, stops = 0, nbit = 0, nbyte = 0, wraps = 0;
    logic [7:0] sh = '0;
    logic [7:0] cap [0:7];
    real t_rise = 0.0, scl_high = 0.0;
    longint unsigned m_res = 0;
    bit finished = 0;

    always @(negedge sda_line) if (scl_o === 1'b1) begin starts++; nbit = 0; nbyte = 0; end
    always @(posedge sda_line) if (scl_o === 1'b1) stops++;
    always @(posedge scl_o) begin
        t_rise = $realtime;
        if (nbit < 8) begin sh = {sh[6:0], sda_line}; nbit++; end
        else begin if (nbyte < 8) cap[nbyte] = sh; nbyte++; nbit = 0; end
    end
    always @(negedge scl_o) begin
        scl_high = $realtime - t_rise;
        slave_pull = (nbit == 8) && slave_ack;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model(input longint unsigned f, input longint unsigned res,
                                  output longint unsigned a, output longint unsigned b,
                                  output longint unsigned rnew);
        longint unsigned r0, n;
        a = f / REF; r0 = f % REF;
        n = r0 * DEN + res;
        b = n / REF; rnew = n % REF;
        if (b == DEN) begin a = a + 1; b = 0; end
    endfunction

    task automatic do_update(input logic [31:0] f, input bit ign, input bit ack, input bit poke);
        longint unsigned ea, eb, er;
        logic [7:0] exp_b [0:6];
        int exp_n;
        model(f, m_res, ea, eb, er);
        if (eb == 0 && (f % REF) * DEN + m_res >= DEN * REF) wraps++;
        ack_ignore = ign; slave_ack = ack;
        starts = 0; stops = 0;
        @(negedge clk); upd_stb = 1'b1; target_hz = f;
        @(negedge clk); upd_stb = 1'b0;
        chk(busy === 1'b1, "R7 busy after strobe", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            upd_stb = 1'b1; target_hz = f + 32'd12345;
            @(negedge clk); upd_stb = 1'b0;
            chk(overrun === 1'b1, "R8 overrun pulse", overrun, 1);
            @(negedge clk);
            chk(overrun === 1'b0, "R8 overrun one cycle", overrun, 0);
        end
        while (busy) @(negedge clk);
        chk(ratio_int == 8'(ea), "R1 integer part", ratio_int, longint'(ea));
        chk(ratio_num == 20'(eb), "R2 R3 numerator", ratio_num, longint'(eb));
        m_res = er;
        exp_b[0] = 8'hC0; exp_b[1] = 8'd26; exp_b[2] = 8'(ea); exp_b[3] = 8'h00;
        exp_b[4] = {4'h0, 4'(eb >> 16)}; exp_b[5] = 8'(eb >> 8); exp_b[6] = 8'(eb);
        exp_n = (!ack && !ign) ? 1 : 7;
        chk(starts == 1 && stops == 1, "R4 one start and stop", starts * 10 + stops, 11);
        chk(nbyte == exp_n, (exp_n == 1) ? "R5 nack byte count" : "R6 R4 byte count", nbyte, exp_n);
        for (int i = 0; i < 7; i++)
            if (i < exp_n && i < nbyte)
                chk(cap[i] == exp_b[i], "R4 frame byte", cap[i], exp_b[i]);
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && overrun === 1'b0, "R7 reset flags", {busy, overrun}, 0);
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R7 reset lines", {scl_o, sda_o}, 3);
        // R1 R2 directed example from reset
        do_update(32'd880200000, 1'b0, 1'b1, 1'b0);
        chk(ratio_int == 8'd32 && ratio_num == 20'h99999, "R2 example 0x99999", ratio_num, 20'h99999);
        chk(scl_high > 39.9 && scl_high < 40.1, "R9 scl high width", longint'(scl_high), 40);
        // R1 below reference
        do_update(32'd20000000, 1'b0, 1'b1, 1'b0);
        // R5 nack stops early, R6 nack ignored
        do_update(32'd900000000, 1'b0, 1'b0, 1'b0);
        do_update(32'd910000000, 1'b1, 1'b0, 1'b0);
        // R8 dropped strobe
        do_update(32'd905000000, 1'b0, 1'b1, 1'b1);
        // R3 rollover
        for (int k = 0; k < 4; k++) do_update(32'd890999999, 1'b1, 1'b1, 1'b0);
        chk(wraps > 0, "R3 rollover seen", wraps, 1);
        // random mix
        for (int k = 0; k < 10; k++)
            do_update(32'd850000000 + ($urandom % 32'd100000000), 1'($urandom % 2), 1'b1, 1'($urandom % 4 == 0));
        finished = 1;
        summary();
    end
endmodule